// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is the device side of a serial memory on an SPI bus in mode 0. It holds a byte array of 2^ADDR_W cells (an 8K x 8 part uses ADDR_W = 13) and a small status register. It decodes a command byte shifted in while chip select is low. The commands are: set or clear the write-enable latch, read or write the status register, and read or write the array. A read or write carries a two-byte start address, then runs for as many bytes as the master clocks.

Bus pins are sampled by the system clock `clk` and pass through a synchronizer of SYNC_STAGES flops (0 when the pins are already in the `clk` domain). SCK edges are detected from the sampled pins. Writes into the array are gated by the write-enable latch and by two block-protect bits. A protect-enable bit decides whether the write-protect pin can lock the status register. A hold pin pauses a transfer without ending it. The serial output is driven as data plus an enable, so the pad can tri-state it.

Top module: `spimem_slave`

## Requirements
- R1: After reset the status register reads 00h, with status bit 1 = write-enable latch, bits 3:2 = block-protect, bit 7 = protect-enable, and all other bits 0.
- R2: Command 06h sets the write-enable latch. Command 04h clears it.
- R3: Command 02h (array write) changes no cell while the latch is clear.
- R4: Commands 03h and 02h take two address bytes, high byte first. Only the low ADDR_W bits of that 16-bit value select the first byte.
- R5: During a burst the address steps by one per byte and wraps from 2^ADDR_W-1 to 0.
- R6: Bytes are shifted MSB first. Each written byte is stored on its eighth SCK rise. A byte cut short by chip select rising is discarded.
- R7: After command 03h and its address, SI is ignored. Each eight SCK cycles shift one cell out on SO, MSB first, changing on falling SCK.
- R8: Chip select rising after a 02h or 01h transfer clears the write-enable latch.
- R9: Hold low (taken while SCK is low) freezes the transfer and disables SO. SCK edges during hold are ignored. Raising hold resumes the transfer at the bit where it stopped.
- R10: Command 01h loads status bits 7 and 3:2 from its data byte. When protect-enable is 1 and the write-protect pin is low, the status bits are left unchanged. When protect-enable is 0, the pin has no effect.
- R11: Block-protect 00 locks no cell, 01 locks the top quarter of the array, 10 the top half, and 11 all cells. Locked cells are never written.
- R12: An unknown command byte, and all bytes after it, change nothing until chip select rises.
- R13: Command 01h changes nothing while the write-enable latch is clear.
- R14: SO enable is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_wp_n | input | 1 | Active-low status write lock |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Drive enable for SO (low = tri-state) |

## Verification
The bench builds the block with ADDR_W = 6 (a 64-byte array) and SYNC_STAGES = 2. The small array lets every block-protect setting be checked by writing and then reading back every cell. Each quarter and half boundary is hit exactly, and wraparound costs only a few extra bytes. The two-stage synchronizer sets the same pin-to-edge delay a real chip would see. Hold, partial bytes, status locking and unknown commands are then checked against an arithmetic model of the array.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
   localparam int BYTE_W = 8;

   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRIT = 8'h02;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR_HI,
      PH_ADDR_LO,
      PH_DATA,
      PH_STAT_RD,
      PH_STAT_WR,
      PH_SKIP
   } spimem_phase_e;

   // bp selects the locked fraction; hi/lo are the two top address bits
   function automatic logic region_locked(input logic [1:0] bp,
                                          input logic hi, input logic lo);
      case (bp)
         2'b11:   return 1'b1;
         2'b10:   return hi;
         2'b01:   return hi & lo;
         default: return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spimem_bitio.sv
module spimem_bitio
   import spimem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              si_s,
   input  logic              hold_n_s,
   input  logic              load_req,
   input  logic [BYTE_W-1:0] load_byte,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              held,
   output logic              cs_rise,
   output logic              so_bit,
   output logic              so_en
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic              sck_q, cs_q, pend;
   logic              cs_active, sck_rise, sck_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] in_sr, out_sr, nxt_byte;

   assign cs_active = !cs_n_s;
   assign sck_rise  = cs_active & ~held & sck_s & ~sck_q;
   assign sck_fall  = cs_active & ~held & ~sck_s & sck_q;
   assign cs_rise   = cs_n_s & ~cs_q;
   assign rx_byte   = {in_sr[BYTE_W-2:0], si_s};
   assign byte_done = sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
   assign so_bit    = out_sr[BYTE_W-1];
   assign so_en     = cs_active & ~held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         cs_q     <= 1'b1;
         held     <= 1'b0;
         pend     <= 1'b0;
         bit_cnt  <= '0;
         in_sr    <= '0;
         out_sr   <= '0;
         nxt_byte <= '0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
         if (cs_n_s) begin
            held    <= 1'b0;
            pend    <= 1'b0;
            bit_cnt <= '0;
         end else begin
            if (!sck_s) held <= !hold_n_s;
            if (sck_rise) begin
               in_sr   <= rx_byte;
               bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (load_req) begin
               pend     <= 1'b1;
               nxt_byte <= load_byte;
            end else if (sck_fall) begin
               if (pend) begin
                  out_sr <= nxt_byte;
                  pend   <= 1'b0;
               end else begin
                  out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [ADDR_W-1:0] ra,
   output logic [DATA_W-1:0] rd
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[wa] <= wd;
   end

   assign rd = cells[ra];
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
   import spimem_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_si,
   input  logic spi_hold_n,
   input  logic spi_wp_n,
   output logic spi_so,
   output logic spi_so_en
);
   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 16)
         else $fatal(1, "spimem_slave: ADDR_W must lie in 4..16");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $fatal(1, "spimem_slave: SYNC_STAGES must lie in 0..4");
   end

   logic sck_s, cs_n_s, si_s, hold_n_s, wp_s;
   logic byte_done, held, cs_rise, load_req, so_bit;
   logic [BYTE_W-1:0] rx_byte, load_byte, rd_data, status_byte;
   logic [ADDR_W-1:0] cur_addr, start_addr, rd_addr, mem_wa;
   logic mem_we, wel, wpen, is_rd, wr_kind, sr_block;
   logic [1:0] bp;
   spimem_phase_e phase;

   spimem_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01011)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_sck, spi_cs_n, spi_si, spi_hold_n, spi_wp_n}),
      .q({sck_s, cs_n_s, si_s, hold_n_s, wp_s})
   );

   spimem_bitio u_bitio (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .si_s(si_s),
      .hold_n_s(hold_n_s), .load_req(load_req), .load_byte(load_byte),
      .byte_done(byte_done), .rx_byte(rx_byte), .held(held),
      .cs_rise(cs_rise), .so_bit(so_bit), .so_en(spi_so_en)
   );

   spimem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
      .clk(clk), .we(mem_we), .wa(mem_wa), .wd(rx_byte),
      .ra(rd_addr), .rd(rd_data)
   );

   generate
      if (ADDR_W > 8) begin : g_wide
         logic [ADDR_W-9:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hi_q <= '0;
            else if (byte_done && phase == PH_ADDR_HI) hi_q <= rx_byte[ADDR_W-9:0];
         end
         assign start_addr = {hi_q, rx_byte};
      end else begin : g_narrow
         assign start_addr = rx_byte[ADDR_W-1:0];
      end
   endgenerate

   assign spi_so      = spi_so_en & so_bit;
   assign status_byte = {wpen, 3'b000, bp, wel, 1'b0};
   assign sr_block    = wpen & ~wp_s;
   assign rd_addr     = (phase == PH_ADDR_LO) ? start_addr : cur_addr;
   assign mem_wa      = cur_addr;
   assign mem_we      = byte_done && phase == PH_DATA && !is_rd && wel &&
                        !region_locked(bp, cur_addr[ADDR_W-1], cur_addr[ADDR_W-2]);
   assign load_req    = byte_done &&
                        ((phase == PH_CMD && rx_byte == OP_RDSR) || phase == PH_STAT_RD ||
                         (is_rd && (phase == PH_ADDR_LO || phase == PH_DATA)));
   assign load_byte   = (phase == PH_CMD || phase == PH_STAT_RD) ? status_byte : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         is_rd    <= 1'b0;
         wr_kind  <= 1'b0;
         wel      <= 1'b0;
         wpen     <= 1'b0;
         bp       <= 2'b00;
         cur_addr <= '0;
      end else if (cs_rise) begin
         phase   <= PH_CMD;
         wr_kind <= 1'b0;
         if (wr_kind) wel <= 1'b0;
      end else if (byte_done) begin
         case (phase)
            PH_CMD: begin
               case (rx_byte)
                  OP_WREN: begin wel <= 1'b1; phase <= PH_SKIP; end
                  OP_WRDI: begin wel <= 1'b0; phase <= PH_SKIP; end
                  OP_RDSR: phase <= PH_STAT_RD;
                  OP_WRSR: begin wr_kind <= 1'b1; phase <= PH_STAT_WR; end
                  OP_READ: begin is_rd <= 1'b1; phase <= PH_ADDR_HI; end
                  OP_WRIT: begin is_rd <= 1'b0; wr_kind <= 1'b1; phase <= PH_ADDR_HI; end
                  default: phase <= PH_SKIP;
               endcase
            end
            PH_ADDR_HI: phase <= PH_ADDR_LO;
            PH_ADDR_LO: begin
               cur_addr <= is_rd ? start_addr + ADDR_W'(1) : start_addr;
               phase    <= PH_DATA;
            end
            PH_DATA: cur_addr <= cur_addr + ADDR_W'(1);
            PH_STAT_WR: begin
               if (wel && !sr_block) begin
                  wpen <= rx_byte[7];
                  bp   <= rx_byte[3:2];
               end
               phase <= PH_SKIP;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/spimem_slave_chk.sv
module spimem_slave_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wel,
   input logic              wpen,
   input logic [1:0]        bp,
   input logic              wp_s,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_wa,
   input logic              held,
   input logic              cs_rise,
   input logic              wr_kind,
   input logic [ADDR_W-1:0] cur_addr
);
   // R3
   we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);
   // R8
   wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && wr_kind) |=> !wel);
   // R11
   full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (bp != 2'b11));
   // R11
   half_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && bp == 2'b10) |-> !mem_wa[ADDR_W-1]);
   // R10
   sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wpen && !wp_s) |=> $stable({wpen, bp}));
   // R9
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> $stable(cur_addr));
endmodule

bind spimem_slave spimem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wel(wel), .wpen(wpen), .bp(bp), .wp_s(wp_s),
   .mem_we(mem_we), .mem_wa(mem_wa), .held(held), .cs_rise(cs_rise),
   .wr_kind(wr_kind), .cur_addr(cur_addr)
);

// File: tb/spimem_slave_test.sv
module spimem_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;
   localparam int HALF = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_en;
   int n_chk = 0, n_fail = 0;
   logic [7:0] model [DEPTH];
   logic [7:0] junk, st;

   always #(CLK_PERIOD/2) clk = ~clk;

   spimem_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_so(so), .spi_so_en(so_en)
   );

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((i * 37 + seed * 53 + 11) & 255);
   endfunction

   function automatic bit locked(input int a, input int b);
      if (b == 3) return 1'b1;
      if (b == 2) return a >= DEPTH / 2;
      if (b == 1) return a >= (3 * DEPTH) / 4;
      return 1'b0;
   endfunction

   task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         if (i == hold_at) begin
            hold_n = 1'b0;
            wclk(HALF);
            for (int k = 0; k < 4; k++) begin
               sck = 1'b1; si = ~si; wclk(HALF);
               check(so_en == 1'b0, "R9 so_en during hold", so_en, 0);
               sck = 1'b0; wclk(HALF);
            end
            hold_n = 1'b1;
            wclk(HALF);
         end
         si = tx[i];
         wclk(HALF);
         rx[i] = so;
         sck = 1'b1;
         wclk(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic cs_down();
      cs_n = 1'b0;
      wclk(HALF);
   endtask

   task automatic cs_up();
      wclk(HALF);
      cs_n = 1'b1;
      wclk(2 * HALF);
   endtask

   task automatic op1(input logic [7:0] op);
      cs_down(); xfer(op, -1, junk); cs_up();
   endtask

   task automatic rd_status(output logic [7:0] s);
      cs_down(); xfer(8'h05, -1, junk); xfer(8'h00, -1, s); cs_up();
   endtask

   task automatic wr_status(input logic [7:0] v);
      op1(8'h06);
      cs_down(); xfer(8'h01, -1, junk); xfer(v, -1, junk); cs_up();
   endtask

   task automatic write_seq(input logic [15:0] a, input int n, input int seed,
                            input bit en, input int b);
      cs_down();
      xfer(8'h02, -1, junk); xfer(a[15:8], -1, junk); xfer(a[7:0], -1, junk);
      for (int i = 0; i < n; i++) begin
         int ad;
         ad = (int'(a) + i) % DEPTH;
         xfer(pat(seed, i), -1, junk);
         if (en && !locked(ad, b)) model[ad] = pat(seed, i);
      end
      cs_up();
   endtask

   task automatic read_seq(input logic [15:0] a, input int n, input string req);
      logic [7:0] r;
      cs_down();
      xfer(8'h03, -1, junk); xfer(a[15:8], -1, junk); xfer(a[7:0], -1, junk);
      for (int i = 0; i < n; i++) begin
         int ad;
         ad = (int'(a) + i) % DEPTH;
         xfer(8'((i * 13 + 5) & 255), -1, r);
         check(r == model[ad], req, r, model[ad]);
      end
      cs_up();
   endtask

   task automatic expect_status(input logic [7:0] e, input string req);
      rd_status(st);
      check(st == e, req, st, e);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
      wclk(5);
      check(so_en == 1'b0, "R14 so_en in reset", so_en, 0);
      rst_n = 1'b1;
      wclk(5);
      expect_status(8'h00, "R1 status after reset");
      check(so_en == 1'b0, "R14 so_en with cs high", so_en, 0);

      // R4 R6: fill whole array, junk in discarded high address bits
      op1(8'h06);
      write_seq(16'hA500, DEPTH, 1, 1'b1, 0);
      expect_status(8'h00, "R8 latch cleared after write");
      // R5 R7 R4: read with wrap and noisy SI
      read_seq(16'hFFE7, DEPTH + 4, "R7 R5 burst read with wrap");

      // R3: no latch, no change
      write_seq(16'h0010, 8, 2, 1'b0, 0);
      read_seq(16'h0010, 8, "R3 write without latch");

      // R5: write across top of array
      op1(8'h06);
      write_seq(16'(DEPTH - 2), 4, 3, 1'b1, 0);
      read_seq(16'(DEPTH - 3), 6, "R5 write wrap");

      // R6: partial byte discarded
      op1(8'h06);
      cs_down();
      xfer(8'h02, -1, junk); xfer(8'h00, -1, junk); xfer(8'h08, -1, junk);
      xfer(8'h3C, -1, junk);
      model[8] = 8'h3C;
      for (int k = 0; k < 5; k++) begin
         si = 1'b1; wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
      end
      cs_up();
      read_seq(16'h0008, 3, "R6 byte commit and partial discard");

      // R11: every block-protect code over the whole array
      for (int b = 0; b < 4; b++) begin
         wr_status(8'(b << 2));
         expect_status(8'(b << 2), "R11 protect bits readback");
         op1(8'h06);
         write_seq(16'h0000, DEPTH, 10 + b, 1'b1, b);
         read_seq(16'h0000, DEPTH, "R11 protected region");
      end
      wr_status(8'h00);

      // R10: protect-enable and write-protect pin
      wr_status(8'h80);
      expect_status(8'h80, "R10 protect-enable set");
      wp_n = 1'b0;
      wr_status(8'h8C);
      expect_status(8'h80, "R10 status locked by pin");
      wp_n = 1'b1;
      wr_status(8'h04);
      expect_status(8'h04, "R10 status unlocked by pin high");
      wp_n = 1'b0;
      wr_status(8'h00);
      expect_status(8'h00, "R10 pin ignored when protect-enable clear");
      wp_n = 1'b1;

      // R13: status write needs latch
      cs_down(); xfer(8'h01, -1, junk); xfer(8'h0C, -1, junk); cs_up();
      expect_status(8'h00, "R13 status write without latch");

      // R2
      op1(8'h06);
      expect_status(8'h02, "R2 latch set");
      op1(8'h04);
      expect_status(8'h00, "R2 latch cleared");

      // R12: unknown command and trailing bytes ignored
      op1(8'h06);
      cs_down();
      xfer(8'hAB, -1, junk); xfer(8'h02, -1, junk); xfer(8'h00, -1, junk);
      xfer(8'h04, -1, junk); xfer(8'h77, -1, junk);
      cs_up();
      expect_status(8'h02, "R12 unknown command keeps latch");
      read_seq(16'h0000, 8, "R12 unknown command keeps array");
      op1(8'h04);

      // R9: hold in the middle of read and write bytes
      cs_down();
      xfer(8'h03, -1, junk); xfer(8'h00, -1, junk); xfer(8'h20, -1, junk);
      xfer(8'h00, 4, st);
      check(st == model[32], "R9 read across hold", st, model[32]);
      xfer(8'h00, -1, st);
      check(st == model[33], "R9 read after hold", st, model[33]);
      cs_up();
      op1(8'h06);
      cs_down();
      xfer(8'h02, -1, junk); xfer(8'h00, -1, junk); xfer(8'h30, -1, junk);
      xfer(8'h5A, 3, junk); xfer(8'hC3, 7, junk);
      cs_up();
      model[48] = 8'h5A;
      model[49] = 8'hC3;
      read_seq(16'h0030, 3, "R9 write across hold");

      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      summary();
      $finish;
   end
endmodule